// File: doc/BRIEF.md
# Selectable dead-time gate generator

This block turns a single PWM command into two complementary gate enables for a half-bridge. The high-side enable is in phase with the command and the low-side enable is its complement. Between one side switching off and the other switching on, both enables are held low for a dead-time chosen at run time from four presets by a 2-bit mode input. The presets are given in picoseconds and turned into clock-cycle counts from a clock-period parameter.

Command pulses narrower than a minimum width are filtered out before they can reach the gates. A shutdown input from the protection logic forces both enables low. When shutdown is released, both stay low for one full dead-time before the side chosen by the filtered command turns on. The mode is only captured while both enables are off, so an interval in progress never changes length.

Top module: `dtg_gate_gen`

## Requirements
- R1: Outside dead-time and shutdown, `hs_o` equals the filtered PWM command and `ls_o` equals its complement.
- R2: Mode 3 selects the 15 ns preset, mode 2 selects 25 ns, mode 1 selects 35 ns and mode 0 selects 45 ns. Each preset lasts ceil(preset / clock period) cycles, with a minimum of 1.
- R3: The same selected dead-time separates low-side off from high-side on and high-side off from low-side on. One side never turns on in the cycle right after the other turns off.
- R4: A shutdown sampled high on a clock edge drives both outputs low from that edge on, for as long as it stays high.
- R5: A change on `pwm_i` reaches the outputs only after the new level has been sampled on ceil(min pulse / clock period) consecutive edges. Shorter pulses are dropped.
- R6: The mode is captured at the edge where the outputs go off, and on every edge while shutdown is held. A mode change during a dead interval has no effect on that interval.
- R7: After shutdown is released, the side selected by the filtered command turns on at the N-th rising edge, where N is the cycle count of the captured preset.
- R8: `hs_o` and `ls_o` are never high in the same cycle.
- R9: During reset both outputs are low. After reset, the longest preset (45 ns) elapses before the first output turns on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command, high requests the high side |
| mode_i | input | 2 | Dead-time preset select, 3 gives the shortest and 0 the longest |
| sd_i | input | 1 | Shutdown, high forces both outputs off |
| hs_o | output | 1 | High-side gate enable |
| ls_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with a 5 ns clock. This turns the presets into 3, 5, 7 and 9 cycles and the minimum pulse into 2 cycles. With these values, a one-cycle glitch, a pulse of exactly the minimum width, and every preset boundary can be reached within a few cycles of each other. A random run of command, mode and shutdown changes is then compared cycle by cycle against a behavioural model.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    ST_DEAD = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } dtg_state_e;

  // ceil(ps / clk_ps), never below one cycle
  function automatic int ps_to_cycles(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/dtg_preset_table.sv
module dtg_preset_table
  import dtg_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int DT_MIN_PS     = 15000,
  parameter int DT_STEP_PS    = 10000,
  parameter int CW            = 4
) (
  input  logic [1:0]    mode_i,
  output logic [CW-1:0] dt_cyc_o
);

  localparam int NMODES = 4;

  logic [CW-1:0] tbl [NMODES];

  // highest mode code gives the shortest preset
  for (genvar g = 0; g < NMODES; g++) begin : g_tbl
    localparam int CYC = ps_to_cycles(DT_MIN_PS + (NMODES - 1 - g) * DT_STEP_PS,
                                      CLK_PERIOD_PS);
    assign tbl[g] = CW'(CYC);
  end

  assign dt_cyc_o = tbl[mode_i];

endmodule

// File: rtl/dtg_pulse_filter.sv
module dtg_pulse_filter #(
  parameter int MIN_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic filt_o
);

  logic filt_q;

  if (MIN_CYC <= 1) begin : g_pass
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) filt_q <= 1'b0;
      else         filt_q <= pwm_i;
    end
  end else begin : g_filt
    localparam int RW = $clog2(MIN_CYC + 1);

    logic          raw_q;
    logic [RW-1:0] run_q, run_nx;

    always_comb begin
      if (pwm_i != raw_q)          run_nx = RW'(1);
      else if (run_q == RW'(MIN_CYC)) run_nx = run_q;
      else                         run_nx = run_q + RW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_q  <= 1'b0;
        run_q  <= '0;
        filt_q <= 1'b0;
      end else begin
        raw_q <= pwm_i;
        run_q <= run_nx;
        if (run_nx == RW'(MIN_CYC)) filt_q <= pwm_i;
      end
    end

    // R5: a filtered edge needs the level already present on the prior sample
    assert_rise_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(filt_q) |-> $past(raw_q));
    assert_fall_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(filt_q) |-> !$past(raw_q));
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/dtg_dead_fsm.sv
module dtg_dead_fsm
  import dtg_pkg::*;
#(
  parameter int CW       = 4,
  parameter int DT_RESET = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          filt_i,
  input  logic          sd_i,
  input  logic [CW-1:0] dt_sel_i,
  output logic          hs_o,
  output logic          ls_o
);

  dtg_state_e    state_q;
  logic [CW-1:0] cnt_q, dt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DEAD;
      cnt_q   <= '0;
      dt_q    <= CW'(DT_RESET);
    end else begin
      unique case (state_q)
        ST_DEAD: begin
          if (sd_i) begin
            cnt_q <= '0;
            dt_q  <= dt_sel_i;
          end else if (cnt_nx >= dt_q) begin
            state_q <= filt_i ? ST_HIGH : ST_LOW;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
        ST_HIGH: if (sd_i || !filt_i) begin
          state_q <= ST_DEAD;
          cnt_q   <= '0;
          dt_q    <= dt_sel_i;
        end
        ST_LOW: if (sd_i || filt_i) begin
          state_q <= ST_DEAD;
          cnt_q   <= '0;
          dt_q    <= dt_sel_i;
        end
        default: state_q <= ST_DEAD;
      endcase
    end
  end

  assign hs_o = (state_q == ST_HIGH);
  assign ls_o = (state_q == ST_LOW);

  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  assert_sd_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |=> (!hs_o && !ls_o));
  assert_dt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD && !sd_i) |=> $stable(dt_q));
  assert_no_swap_hl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_o) |-> !ls_o);
  assert_no_swap_lh_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_o) |-> !hs_o);

endmodule

// File: rtl/dtg_gate_gen.sv
module dtg_gate_gen
  import dtg_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int DT_MIN_PS     = 15000,
  parameter int DT_STEP_PS    = 10000,
  parameter int MIN_PULSE_PS  = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_i,
  input  logic [1:0] mode_i,
  input  logic       sd_i,
  output logic       hs_o,
  output logic       ls_o
);

  localparam int MIN_CYC = ps_to_cycles(MIN_PULSE_PS, CLK_PERIOD_PS);
  localparam int DT_MAX  = ps_to_cycles(DT_MIN_PS + 3 * DT_STEP_PS, CLK_PERIOD_PS);
  localparam int CW      = $clog2(DT_MAX + 1);

  logic          filt;
  logic [CW-1:0] dt_sel;

  dtg_pulse_filter #(.MIN_CYC(MIN_CYC)) i_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm_i),
    .filt_o (filt)
  );

  dtg_preset_table #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .DT_MIN_PS     (DT_MIN_PS),
    .DT_STEP_PS    (DT_STEP_PS),
    .CW            (CW)
  ) i_table (
    .mode_i   (mode_i),
    .dt_cyc_o (dt_sel)
  );

  dtg_dead_fsm #(.CW(CW), .DT_RESET(DT_MAX)) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .filt_i   (filt),
    .sd_i     (sd_i),
    .dt_sel_i (dt_sel),
    .hs_o     (hs_o),
    .ls_o     (ls_o)
  );

endmodule

// File: tb/test_dtg_gate_gen.sv
`timescale 1ns/1ps
module test_dtg_gate_gen;

  localparam real CLK_PERIOD = 5.0;
  localparam int  CLK_PS     = 5000;
  localparam int  MINP       = (10000 + CLK_PS - 1) / CLK_PS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       sd = 1'b0;
  logic       hs, ls;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dtg_gate_gen #(.CLK_PERIOD_PS(CLK_PS)) i_dtg_gate_gen (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .mode_i(mode), .sd_i(sd),
    .hs_o(hs), .ls_o(ls)
  );

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  function automatic int exp_dt(input int m);
    return (15000 + (3 - m) * 10000 + CLK_PS - 1) / CLK_PS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 dead, 1 high on, 2 low on
  int mst, mcnt, mdt, mrun;
  bit mraw, mfilt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mcnt = 0; mdt = exp_dt(0); mrun = 0; mraw = 0; mfilt = 0;
    end else begin
      if (mst == 0) begin
        if (sd) begin mcnt = 0; mdt = exp_dt(mode); end
        else if (mcnt + 1 >= mdt) begin mst = mfilt ? 1 : 2; mcnt = 0; end
        else mcnt++;
      end else if (sd || (mst == 1) != mfilt) begin
        mst = 0; mcnt = 0; mdt = exp_dt(mode);
      end
      if (pwm != mraw) mrun = 1; else if (mrun < MINP) mrun++;
      mraw = pwm;
      if (mrun >= MINP) mfilt = pwm;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check(hs == (mst == 1) && ls == (mst == 2), "R1 model", {hs, ls},
          {mst == 1, mst == 2});
    check(!(hs && ls), "R8", {hs, ls}, 0);
  end

  // width of the last both-off gap between two on phases
  int gap = 0, last_gap = 0;
  always @(negedge clk) begin
    if (!rst_n) begin gap = 0; last_gap = 0; end
    else if (!hs && !ls) gap++;
    else begin if (gap > 0) last_gap = gap; gap = 0; end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    check(!hs && !ls, "R9 reset", {hs, ls}, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!ls && n < 50);
    check(n == exp_dt(0), "R9 first on", n, exp_dt(0));

    // every preset, both directions
    for (int m = 3; m >= 0; m--) begin
      @(negedge clk); mode = 2'(m);
      pwm = 1'b1; cyc(25);
      check(hs && last_gap == exp_dt(m), "R2 low-to-high", last_gap, exp_dt(m));
      pwm = 1'b0; cyc(25);
      check(ls && last_gap == exp_dt(m), "R3 high-to-low", last_gap, exp_dt(m));
    end

    // one-cycle glitch dropped, minimum-width pulse passes
    mode = 2'd3;
    pwm = 1'b1; cyc(1); pwm = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!ls) n++; end
    check(n == 0, "R5 glitch", n, 0);
    pwm = 1'b1; cyc(MINP); pwm = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (!ls) n++; end
    check(n > 0, "R5 min pulse", n, 1);
    cyc(15);

    // mode change inside a dead interval
    mode = 2'd0; pwm = 1'b1; cyc(4);
    check(!hs && !ls, "R6 in dead", {hs, ls}, 0);
    mode = 2'd3; cyc(20);
    check(hs && last_gap == exp_dt(0), "R6 gap", last_gap, exp_dt(0));

    // shutdown while high side is on
    sd = 1'b1; @(posedge clk); #1;
    check(!hs && !ls, "R4 immediate", {hs, ls}, 0);
    mode = 2'd2; cyc(6);
    check(!hs && !ls, "R4 held", {hs, ls}, 0);
    @(negedge clk); sd = 1'b0;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!hs && n < 50);
    check(n == exp_dt(2), "R7 release", n, exp_dt(2));

    // random mix
    begin
      int hold = 0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if (hold == 0) begin pwm = 1'($urandom); hold = $urandom_range(1, 14); end
        else hold--;
        if ($urandom_range(0, 9) == 0) mode = 2'($urandom);
        if ($urandom_range(0, 99) == 0) sd = ~sd;
      end
      sd = 1'b0;
    end
    cyc(30);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule